// File: doc/BRIEF.md
# Serial Wire Debug Host Packet Engine

This block is the host side of a two-wire serial debug link. It runs one packet at a time on a bidirectional data line, using a bit clock that the host itself drives. A command carries three things: the seven request bits the host drives, a direction flag, and 32 bits of write data. A separate flag selects the special target-select packet, which has no acknowledge phase.

The engine frames each packet with low idle bits and drives the request. It releases the line for the park and turnaround slots and samples the three-bit acknowledge from the target. It then either moves a 32-bit data word with even parity or abandons the data phase. When the packet is finished it returns the acknowledge, the read word and a parity-error flag.

The bit-clock half period is set by a divider of the system clock, which is captured when a command is accepted. The data line has a value output and a separate output enable. When the enable is low, the line is expected to read high through an external pull-up.

Top module: `swd_host`

## Requirements
- R1: Every field is sent and received least significant bit first. After the leading idle bits the host drives the seven bits of `cmdReq`, bit 0 first, with the output enable high.
- R2: On a normal packet the host releases the line (`swdioOe`=0) for the park bit and then for one turnaround bit. It then samples three acknowledge bits and reports them on `rspAck` in the order received: 3'b001 is OK, 3'b010 is WAIT, 3'b100 is FAULT.
- R3: On a write with an OK acknowledge, one more released turnaround bit follows. The host then drives the 32 data bits and an even-parity bit computed over them.
- R4: On a read with an OK acknowledge, the host samples 32 data bits and a parity bit straight after the acknowledge, with no gap. It then releases the line for one turnaround bit, and `rspRdata` returns the word.
- R5: When the acknowledge is not 3'b001, the host releases one turnaround bit and goes straight to the trailing idle bits with no data phase. `rspRdata` reads zero and `rspParityErr` reads zero.
- R6: When the received read parity does not match the data, `rspParityErr` is 1, `rspRdata` is zero and `rspAck` still shows 3'b001.
- R7: A target-select packet (`cmdTsel`=1) releases the line for six bits after the request, and whatever is on the line then has no effect. It then drives 32 data bits and their even parity, and reports `rspAck` = 3'b000.
- R8: Each bit lasts `halfDiv`+1 system cycles with `swclk` low, then `halfDiv`+1 cycles with `swclk` high. The line output changes only at the start of the low half, and the input is sampled on the last system cycle of the low half.
- R9: Each packet begins and ends with eight bits driven low. While no packet is in flight, `swclk` is 0, `swdioOe` is 1 and `swdioOut` is 0.
- R10: `cmdReady` equals the inverse of `busy`, and a command is taken when `cmdValid` and `cmdReady` are both high. `busy` is high from the next cycle until the cycle in which `rspValid` pulses for one cycle. The result outputs hold their values until the next result.
- R11: `rspValid` rises 2*(`halfDiv`+1)*N cycles after the accepting edge. N is 62 bits for any packet with a data phase and 29 bits for a packet whose acknowledge is not OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine can take a command |
| cmdReq | input | 7 | Request bits driven on the line, bit 0 first |
| cmdRead | input | 1 | 1 selects a read data phase, 0 a write |
| cmdTsel | input | 1 | 1 selects the target-select packet form |
| cmdWdata | input | 32 | Write data |
| halfDiv | input | DIV_W | Bit-clock half period minus one, in system cycles |
| busy | output | 1 | Packet in flight |
| rspValid | output | 1 | One-cycle result strobe |
| rspAck | output | 3 | Acknowledge as received, 3'b000 for target-select |
| rspRdata | output | 32 | Read word, zero unless a clean read |
| rspParityErr | output | 1 | Read parity mismatch |
| swclk | output | 1 | Bit clock to the target |
| swdioOut | output | 1 | Data line value |
| swdioOe | output | 1 | Data line output enable |
| swdioIn | input | 1 | Data line as seen at the pin |

## Verification
For every packet, the bench builds its own queue of expected bit slots. Each slot records whether the host drives the line, the driven value, and the level the target model presents. On each system cycle the bench works out the bit index and the position inside the bit from the cycle count since acceptance. It then compares `swclk`, `swdioOe` and `swdioOut` in the same cycle. Target levels are applied at the falling system edge, so each one is settled before the sampling edge at the end of the low half. The result is checked exactly 2*(`halfDiv`+1)*N cycles after acceptance, and checked again one cycle later to confirm the strobe has dropped while the values hold.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD, PH_REQ, PH_PARK, PH_TURNA, PH_ACK, PH_TURNW,
    PH_WDATA, PH_WPAR, PH_RDATA, PH_RPAR, PH_TURNE, PH_TAIL
  } phase_e;

  typedef enum logic [1:0] {SRC_ZERO, SRC_SHIFT, SRC_PARITY} src_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;     // command accepted this cycle
    logic run;       // bit timer running
    logic loadData;  // move write word into the shifter
    logic shiftTx;   // advance the transmit shifter
    logic capAck;    // sample acknowledge bits
    logic capData;   // sample read data bits
    logic capPar;    // sample read parity bit
    logic drive;     // output enable
    src_e src;       // output value source
    logic finish;    // register the result
    logic readPath;  // packet took the read data phase
  } strobe_t;

  localparam logic [2:0] ACK_OK = 3'b001;

endpackage

// File: rtl/swd_host_ctrl.sv
module swd_host_ctrl
  import swd_host_pkg::*;
#(
  parameter int LEAD_BITS = 8,
  parameter int TSEL_GAP  = 6,
  parameter int DATA_W    = 32,
  parameter int REQ_W     = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdRead,
  input  logic       cmdTsel,
  input  logic       bitEnd,
  input  logic [2:0] ackNow,
  output logic       cmdReady,
  output logic       busy,
  output strobe_t    ctl
);

  localparam int MAXB  = (DATA_W > LEAD_BITS) ? DATA_W : LEAD_BITS;
  localparam int CNT_W = $clog2(MAXB);

  phase_e state, nxt;
  logic [CNT_W-1:0] bitCnt, nxtCnt;
  logic isRead, isTsel, rdPath;
  logic accept, advance;

  function automatic logic [CNT_W-1:0] span(input int n);
    return CNT_W'(n - 1);
  endfunction

  assign accept  = cmdValid && (state == PH_IDLE);
  assign advance = bitEnd && (bitCnt == '0);
  assign busy    = (state != PH_IDLE);
  assign cmdReady = !busy;

  always_comb begin
    nxt    = state;
    nxtCnt = bitEnd ? bitCnt - 1'b1 : bitCnt;
    if (state == PH_IDLE) begin
      if (accept) begin
        nxt    = PH_LEAD;
        nxtCnt = span(LEAD_BITS);
      end
    end else if (advance) begin
      case (state)
        PH_LEAD:  begin nxt = PH_REQ;  nxtCnt = span(REQ_W); end
        PH_REQ:   begin nxt = PH_PARK; nxtCnt = isTsel ? span(TSEL_GAP) : span(1); end
        PH_PARK:  begin
          if (isTsel) begin nxt = PH_WDATA; nxtCnt = span(DATA_W); end
          else        begin nxt = PH_TURNA; nxtCnt = span(1); end
        end
        PH_TURNA: begin nxt = PH_ACK; nxtCnt = span(3); end
        PH_ACK:   begin
          if (ackNow != ACK_OK) begin nxt = PH_TURNE; nxtCnt = span(1); end
          else if (isRead)      begin nxt = PH_RDATA; nxtCnt = span(DATA_W); end
          else                  begin nxt = PH_TURNW; nxtCnt = span(1); end
        end
        PH_TURNW: begin nxt = PH_WDATA; nxtCnt = span(DATA_W); end
        PH_WDATA: begin nxt = PH_WPAR;  nxtCnt = span(1); end
        PH_WPAR:  begin nxt = PH_TAIL;  nxtCnt = span(LEAD_BITS); end
        PH_RDATA: begin nxt = PH_RPAR;  nxtCnt = span(1); end
        PH_RPAR:  begin nxt = PH_TURNE; nxtCnt = span(1); end
        PH_TURNE: begin nxt = PH_TAIL;  nxtCnt = span(LEAD_BITS); end
        PH_TAIL:  begin nxt = PH_IDLE;  nxtCnt = '0; end
        default:  begin nxt = PH_IDLE;  nxtCnt = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      isTsel <= 1'b0;
      rdPath <= 1'b0;
    end else begin
      state  <= nxt;
      bitCnt <= nxtCnt;
      if (accept) begin
        isRead <= cmdRead;
        isTsel <= cmdTsel;
        rdPath <= 1'b0;
      end else if (advance && nxt == PH_RDATA) begin
        rdPath <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.start    = accept;
    ctl.run      = busy;
    ctl.loadData = advance && (nxt == PH_WDATA);
    ctl.shiftTx  = bitEnd && (state == PH_REQ || state == PH_WDATA);
    ctl.capAck   = (state == PH_ACK);
    ctl.capData  = (state == PH_RDATA);
    ctl.capPar   = (state == PH_RPAR);
    ctl.finish   = advance && (state == PH_TAIL);
    ctl.readPath = rdPath;
    case (state)
      PH_IDLE, PH_LEAD, PH_TAIL: begin ctl.drive = 1'b1; ctl.src = SRC_ZERO;   end
      PH_REQ, PH_WDATA:          begin ctl.drive = 1'b1; ctl.src = SRC_SHIFT;  end
      PH_WPAR:                   begin ctl.drive = 1'b1; ctl.src = SRC_PARITY; end
      default:                   begin ctl.drive = 1'b0; ctl.src = SRC_ZERO;   end
    endcase
  end

  // a data phase after the acknowledge only follows an OK acknowledge
  assert_ok_before_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_RDATA || state == PH_TURNW) |-> ackNow == ACK_OK);

  // target-select never samples an acknowledge
  assert_tsel_no_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WDATA && isTsel) |-> ackNow == 3'b000);

endmodule

// File: rtl/swd_host_datapath.sv
module swd_host_datapath
  import swd_host_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32,
  parameter int REQ_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [REQ_W-1:0]  cmdReq,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              swdioIn,
  output logic              bitEnd,
  output logic [2:0]        ackNow,
  output logic              swclk,
  output logic              swdioOut,
  output logic              swdioOe,
  output logic              rspValid,
  output logic [2:0]        rspAck,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspParityErr
);

  logic [DIV_W-1:0]  halfLat, phCnt;
  logic              highPh, phEnd, bitSample;
  logic [DATA_W-1:0] txSh, wdLat, rxSh;
  logic              wPar, rPar, parOk;
  logic [2:0]        ackSh;

  // bit timer: low half then high half, each halfLat+1 cycles
  assign phEnd     = (phCnt == halfLat);
  assign bitSample = ctl.run && !highPh && phEnd;
  assign bitEnd    = ctl.run && highPh && phEnd;
  assign swclk     = ctl.run && highPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfLat <= '0;
      phCnt   <= '0;
      highPh  <= 1'b0;
    end else if (ctl.start) begin
      halfLat <= halfDiv;
      phCnt   <= '0;
      highPh  <= 1'b0;
    end else if (ctl.run) begin
      if (phEnd) begin
        phCnt  <= '0;
        highPh <= !highPh;
      end else begin
        phCnt <= phCnt + 1'b1;
      end
    end
  end

  // transmit side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      wdLat <= '0;
      wPar  <= 1'b0;
    end else if (ctl.start) begin
      txSh  <= {{(DATA_W-REQ_W){1'b0}}, cmdReq};
      wdLat <= cmdWdata;
      wPar  <= ^cmdWdata;
    end else if (ctl.loadData) begin
      txSh <= wdLat;
    end else if (ctl.shiftTx) begin
      txSh <= {1'b0, txSh[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (ctl.src)
      SRC_SHIFT:  swdioOut = ctl.drive && txSh[0];
      SRC_PARITY: swdioOut = ctl.drive && wPar;
      default:    swdioOut = 1'b0;
    endcase
  end
  assign swdioOe = ctl.drive;

  // receive side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSh <= '0;
      rxSh  <= '0;
      rPar  <= 1'b0;
    end else if (ctl.start) begin
      ackSh <= '0;
      rxSh  <= '0;
      rPar  <= 1'b0;
    end else if (bitSample) begin
      if (ctl.capAck)  ackSh <= {swdioIn, ackSh[2:1]};
      if (ctl.capData) rxSh  <= {swdioIn, rxSh[DATA_W-1:1]};
      if (ctl.capPar)  rPar  <= swdioIn;
    end
  end

  assign ackNow = ackSh;
  assign parOk  = ((^rxSh) == rPar);

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAck       <= '0;
      rspRdata     <= '0;
      rspParityErr <= 1'b0;
    end else begin
      rspValid <= ctl.finish;
      if (ctl.finish) begin
        rspAck       <= ackSh;
        rspParityErr <= ctl.readPath && !parOk;
        rspRdata     <= (ctl.readPath && parOk) ? rxSh : '0;
      end
    end
  end

  // the line is set up during the low half and holds across the rising edge
  assert_setup_before_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swclk) |-> ($stable(swdioOut) && $stable(swdioOe)));

  // a parity failure never hands out data
  assert_no_data_on_bad_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspParityErr) |-> rspRdata == '0);

endmodule

// File: rtl/swd_host.sv
module swd_host
  import swd_host_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int LEAD_BITS = 8,
  parameter int TSEL_GAP  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [6:0]       cmdReq,
  input  logic             cmdRead,
  input  logic             cmdTsel,
  input  logic [31:0]      cmdWdata,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             busy,
  output logic             rspValid,
  output logic [2:0]       rspAck,
  output logic [31:0]      rspRdata,
  output logic             rspParityErr,
  output logic             swclk,
  output logic             swdioOut,
  output logic             swdioOe,
  input  logic             swdioIn
);

  localparam int DATA_W = 32;
  localparam int REQ_W  = 7;

  strobe_t    ctl;
  logic       bitEnd;
  logic [2:0] ackNow;

  swd_host_ctrl #(
    .LEAD_BITS(LEAD_BITS), .TSEL_GAP(TSEL_GAP), .DATA_W(DATA_W), .REQ_W(REQ_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdTsel(cmdTsel), .bitEnd(bitEnd), .ackNow(ackNow),
    .cmdReady(cmdReady), .busy(busy), .ctl(ctl)
  );

  swd_host_datapath #(
    .DIV_W(DIV_W), .DATA_W(DATA_W), .REQ_W(REQ_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdReq(cmdReq), .cmdWdata(cmdWdata),
    .halfDiv(halfDiv), .swdioIn(swdioIn), .bitEnd(bitEnd), .ackNow(ackNow),
    .swclk(swclk), .swdioOut(swdioOut), .swdioOe(swdioOe),
    .rspValid(rspValid), .rspAck(rspAck), .rspRdata(rspRdata),
    .rspParityErr(rspParityErr)
  );

  // at rest the clock is low and the line is driven low
  assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!swclk && swdioOe && !swdioOut));

  // the result strobe marks the end of a busy period
  assert_rsp_ends_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!busy && $past(busy)));

endmodule

// File: tb/swd_host_test.sv
module swd_host_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [6:0]  cmdReq = '0;
  logic        cmdRead = 1'b0;
  logic        cmdTsel = 1'b0;
  logic [31:0] cmdWdata = '0;
  logic [7:0]  halfDiv = '0;
  logic        busy, rspValid, rspParityErr, swclk, swdioOut, swdioOe;
  logic [2:0]  rspAck;
  logic [31:0] rspRdata;
  logic        swdioIn = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = !clk;

  swd_host uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdReq(cmdReq), .cmdRead(cmdRead), .cmdTsel(cmdTsel), .cmdWdata(cmdWdata),
    .halfDiv(halfDiv), .busy(busy), .rspValid(rspValid), .rspAck(rspAck),
    .rspRdata(rspRdata), .rspParityErr(rspParityErr), .swclk(swclk),
    .swdioOut(swdioOut), .swdioOe(swdioOe), .swdioIn(swdioIn)
  );

  typedef struct {
    bit    oe;
    bit    val;
    bit    tin;
    string tag;
  } slot_t;

  slot_t sched[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic hostBits(input logic [31:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) sched.push_back('{1'b1, v[i], 1'b0, tag});
  endtask

  task automatic relBits(input logic [31:0] v, input int n, input string tag);
    for (int i = 0; i < n; i++) sched.push_back('{1'b0, 1'b0, v[i], tag});
  endtask

  task automatic runTxn(input logic [6:0] req, input bit rd, input bit ts,
                        input logic [31:0] wd, input logic [2:0] ack,
                        input logic [31:0] rdat, input bit badPar, input int hd);
    logic [2:0]  expAck;
    logic [31:0] expRd;
    bit          expPe;
    int          h;
    h = hd + 1;
    sched.delete();
    hostBits(32'h0, 8, "R9");
    hostBits({25'h0, req}, 7, "R1");
    if (ts) begin
      relBits(32'h16, 6, "R7");                // junk during the gap is ignored
      hostBits(wd, 32, "R7");
      hostBits({31'h0, ^wd}, 1, "R7");
    end else begin
      relBits(32'h1, 1, "R2");                 // park, pulled up
      relBits(32'h1, 1, "R2");                 // turnaround
      relBits({29'h0, ack}, 3, "R2");
      if (ack == 3'b001) begin
        if (!rd) begin
          relBits(32'h1, 1, "R3");
          hostBits(wd, 32, "R3");
          hostBits({31'h0, ^wd}, 1, "R3");
        end else begin
          relBits(rdat, 32, "R4");
          relBits({31'h0, (^rdat) ^ badPar}, 1, "R6");
          relBits(32'h1, 1, "R4");
        end
      end else begin
        relBits(32'h1, 1, "R5");
      end
    end
    hostBits(32'h0, 8, "R9");
    expAck = ts ? 3'b000 : ack;
    expPe  = !ts && rd && (ack == 3'b001) && badPar;
    expRd  = (!ts && rd && (ack == 3'b001) && !badPar) ? rdat : 32'h0;

    @(negedge clk);
    cmdReq = req; cmdRead = rd; cmdTsel = ts; cmdWdata = wd;
    halfDiv = 8'(hd); cmdValid = 1'b1;
    chk(cmdReady == 1'b1, "R10", "ready before accept", {31'h0, cmdReady}, 32'h1);
    @(posedge clk);
    for (int b = 0; b < sched.size(); b++) begin
      for (int p = 0; p < 2 * h; p++) begin
        @(negedge clk);
        cmdValid = 1'b0;
        swdioIn = sched[b].oe ? sched[b].val : sched[b].tin;
        chk(swclk == (p >= h), "R8", $sformatf("swclk bit %0d ph %0d", b, p),
            {31'h0, swclk}, {31'h0, p >= h});
        chk(swdioOe == sched[b].oe, sched[b].tag, $sformatf("oe bit %0d", b),
            {31'h0, swdioOe}, {31'h0, sched[b].oe});
        if (sched[b].oe)
          chk(swdioOut == sched[b].val, sched[b].tag, $sformatf("out bit %0d", b),
              {31'h0, swdioOut}, {31'h0, sched[b].val});
        if (p == 0)
          chk(busy && !cmdReady && !rspValid, "R10", "busy in flight",
              {29'h0, busy, cmdReady, rspValid}, 32'h4);
      end
    end
    @(negedge clk);
    swdioIn = 1'b0;
    chk(rspValid == 1'b1, "R11", "rspValid due", {31'h0, rspValid}, 32'h1);
    chk(busy == 1'b0, "R10", "busy low with result", {31'h0, busy}, 32'h0);
    chk(rspAck == expAck, ts ? "R7" : "R2", "ack", {29'h0, rspAck}, {29'h0, expAck});
    chk(rspRdata == expRd, rd ? "R4" : "R5", "rdata", rspRdata, expRd);
    chk(rspParityErr == expPe, "R6", "parity flag", {31'h0, rspParityErr}, {31'h0, expPe});
    @(negedge clk);
    chk(!rspValid && rspRdata == expRd && rspAck == expAck, "R10", "held, strobe dropped",
        {31'h0, rspValid}, 32'h0);
    chk(!swclk && swdioOe && !swdioOut, "R9", "idle line",
        {29'h0, swclk, swdioOe, swdioOut}, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!swclk && swdioOe && !swdioOut, "R9", "line in reset",
        {29'h0, swclk, swdioOe, swdioOut}, 32'h2);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady && !busy && !rspValid, "R10", "reset handshake",
        {29'h0, cmdReady, busy, rspValid}, 32'h4);
    chk(rspAck == 3'b000 && rspRdata == 32'h0, "R10", "reset result", rspRdata, 32'h0);
    // write, OK acknowledge
    runTxn(7'h3B, 1'b0, 1'b0, 32'hA5C3_0F01, 3'b001, 32'h0, 1'b0, 1);
    // read, OK acknowledge, fastest clock
    runTxn(7'h1F, 1'b1, 1'b0, 32'h0, 3'b001, 32'h1234_5678, 1'b0, 0);
    // read with a bad parity bit
    runTxn(7'h1F, 1'b1, 1'b0, 32'h0, 3'b001, 32'hDEAD_BEEF, 1'b1, 1);
    // write answered with WAIT
    runTxn(7'h3B, 1'b0, 1'b0, 32'hFFFF_0000, 3'b010, 32'h0, 1'b0, 1);
    // read answered with FAULT
    runTxn(7'h0D, 1'b1, 1'b0, 32'h0, 3'b100, 32'h5555_AAAA, 1'b0, 2);
    // target-select
    runTxn(7'h19, 1'b0, 1'b1, 32'h0100_2927, 3'b000, 32'h0, 1'b0, 1);
    // write with odd-weight data and slow clock
    runTxn(7'h23, 1'b0, 1'b0, 32'h0000_0007, 3'b001, 32'h0, 1'b0, 3);
    // read of an all-zero word
    runTxn(7'h1F, 1'b1, 1'b0, 32'h0, 3'b001, 32'h0, 1'b0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule